// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block is a direct-mapped, tagged cache that is consulted in the same cycle as the instruction fetch. The fetch address selects one entry. A single tag guards both the cached branch target and a two-bit direction counter. When the entry is valid, its tag matches and the counter predicts taken, the cached target is driven as the next fetch address in that same cycle, so a predicted-taken branch adds no bubble. Otherwise the next fetch address is the sequential one.

Training arrives on one update stream. When a branch resolves, the counter of its entry is trained. When decode finds a taken branch that the buffer missed, that branch has already lost at least one cycle; decode then requests an allocation, which overwrites the indexed entry. A flush input invalidates every entry in one cycle. While a flush is asserted, the update stream deasserts ready and no update is taken. A producer must hold its request until it sees valid and ready high together on a clock edge.

Top module: `btb_core`

## Requirements
- R1: After reset every entry is invalid: every lookup reports a miss, and next_pc equals fetch_pc plus FETCH_BYTES (4 by default).
- R2: The lookup is combinational on fetch_pc. The entry index is fetch_pc[IDX_W+1:2] and the tag is the bits above the index. pred_hit is 1 only when the indexed entry is valid and its tag equals the fetch tag. On a hit, pred_ctr shows the entry's counter.
- R3: On a hit whose counter MSB is 1 (value 2 or 3), pred_taken is 1 and next_pc equals the cached target in the same cycle.
- R4: On a miss, or on a hit whose counter is 0 or 1, pred_taken is 0 and next_pc equals fetch_pc plus FETCH_BYTES.
- R5: An accepted update with upd_alloc=1 overwrites the indexed entry: valid is set, the tag and target are written, and the counter becomes weakly taken (2). The new contents are visible to lookups from the next cycle on.
- R6: An accepted update with upd_alloc=0 that matches a valid entry trains the counter. Taken adds one, saturating at 3. Not-taken subtracts one, saturating at 0. A taken training update also replaces the target.
- R7: An accepted update with upd_alloc=0 that does not match the indexed entry (invalid, or a different tag) leaves that entry unchanged.
- R8: A cycle with flush=1 clears every valid bit at the next edge. During that cycle upd_ready is 0 and no update is accepted.
- R9: Two addresses that share an index but differ in tag alias to the same entry. Allocating one of them evicts the other, which then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| fetch_pc | input | ADDR_W | Current fetch address |
| pred_hit | output | 1 | Indexed entry is valid and its tag matches |
| pred_taken | output | 1 | Hit with the counter predicting taken |
| pred_target | output | ADDR_W | Cached target of the indexed entry |
| pred_ctr | output | 2 | Counter of the indexed entry |
| next_pc | output | ADDR_W | Next fetch address |
| upd_valid | input | 1 | Update request present |
| upd_ready | output | 1 | Update can be accepted this cycle |
| upd_alloc | input | 1 | 1 = allocate from decode, 0 = train on resolve |
| upd_pc | input | ADDR_W | Address of the branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target |

## Verification
The assertions check four behaviours on every cycle:
- A flush is followed by a miss.
- A fresh allocation is read back as weakly taken at the same address.
- Saturation at the strongly-taken end holds.
- A training update that does not match leaves that address missing.

Only the bench's scenarios can show the following:
- The full counter walk in both directions, including saturation at zero.
- Target refresh on a taken training update.
- Index aliasing and eviction.
- The same-cycle choice between the redirect and the sequential address.
- Back-pressure while a flush is asserted.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam logic [1:0] CTR_SNT = 2'd0;
  localparam logic [1:0] CTR_WNT = 2'd1;
  localparam logic [1:0] CTR_WT  = 2'd2;
  localparam logic [1:0] CTR_ST  = 2'd3;

  function automatic logic [1:0] ctr_train(input logic [1:0] c, input logic taken);
    logic [1:0] r;
    if (taken) r = (c == CTR_ST) ? CTR_ST : c + 2'd1;
    else       r = (c == CTR_SNT) ? CTR_SNT : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/btb_entry_store.sv
module btb_entry_store #(
  parameter int ENTRIES = 256,
  parameter int TAG_W   = 22,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic [1:0]        wr_ctr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_target,
  output logic [1:0]        rd_ctr,
  input  logic [IDX_W-1:0]  tr_idx,
  output logic              tr_valid,
  output logic [TAG_W-1:0]  tr_tag,
  output logic [ADDR_W-1:0] tr_target,
  output logic [1:0]        tr_ctr
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst || flush)                            vld_q[e] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(e))       vld_q[e] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_target;
      ctr_q[wr_idx] <= wr_ctr;
    end
  end

  assign rd_valid  = vld_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_target = tgt_q[rd_idx];
  assign rd_ctr    = ctr_q[rd_idx];
  assign tr_valid  = vld_q[tr_idx];
  assign tr_tag    = tag_q[tr_idx];
  assign tr_target = tgt_q[tr_idx];
  assign tr_ctr    = ctr_q[tr_idx];

  // R8: a flush leaves no entry valid on the following cycle
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));
  // R5: a write without flush marks its entry valid with the written tag
  a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int ADDR_W      = 32,
  parameter int TAG_W       = 22,
  parameter int FETCH_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [TAG_W-1:0]  pc_tag,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [ADDR_W-1:0] ent_target,
  input  logic [1:0]        ent_ctr,
  output logic              hit,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc
);
  logic [ADDR_W-1:0] seq_pc;
  assign seq_pc  = pc + ADDR_W'(FETCH_BYTES);
  assign hit     = ent_valid && (ent_tag == pc_tag);
  assign taken   = hit && ent_ctr[1];
  assign next_pc = taken ? ent_target : seq_pc;
endmodule

// File: rtl/btb_core.sv
module btb_core
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 256,
  parameter int FETCH_BYTES = 4,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int OFF_W      = $clog2(FETCH_BYTES),
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  output logic [1:0]        pred_ctr,
  output logic [ADDR_W-1:0] next_pc,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic              upd_alloc,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  logic [IDX_W-1:0]  f_idx, u_idx;
  logic [TAG_W-1:0]  f_tag, u_tag;
  logic              rd_valid, tr_valid;
  logic [TAG_W-1:0]  rd_tag, tr_tag;
  logic [ADDR_W-1:0] rd_target, tr_target;
  logic [1:0]        rd_ctr, tr_ctr;
  logic              upd_fire, trn_hit, wr_en;
  logic [ADDR_W-1:0] wr_target;
  logic [1:0]        wr_ctr;

  assign f_idx = fetch_pc[OFF_W +: IDX_W];
  assign f_tag = fetch_pc[ADDR_W-1 -: TAG_W];
  assign u_idx = upd_pc[OFF_W +: IDX_W];
  assign u_tag = upd_pc[ADDR_W-1 -: TAG_W];

  assign upd_ready = !flush;
  assign upd_fire  = upd_valid && upd_ready;
  assign trn_hit   = tr_valid && (tr_tag == u_tag);

  always_comb begin
    wr_en     = 1'b0;
    wr_target = tr_target;
    wr_ctr    = tr_ctr;
    if (upd_fire) begin
      if (upd_alloc) begin
        wr_en     = 1'b1;
        wr_target = upd_target;
        wr_ctr    = CTR_WT;
      end else if (trn_hit) begin
        wr_en     = 1'b1;
        wr_target = upd_taken ? upd_target : tr_target;
        wr_ctr    = ctr_train(tr_ctr, upd_taken);
      end
    end
  end

  btb_entry_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(u_tag), .wr_target(wr_target), .wr_ctr(wr_ctr),
    .rd_idx(f_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_target(rd_target), .rd_ctr(rd_ctr),
    .tr_idx(u_idx), .tr_valid(tr_valid), .tr_tag(tr_tag), .tr_target(tr_target), .tr_ctr(tr_ctr)
  );

  btb_match #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .FETCH_BYTES(FETCH_BYTES)) u_match (
    .pc(fetch_pc), .pc_tag(f_tag),
    .ent_valid(rd_valid), .ent_tag(rd_tag), .ent_target(rd_target), .ent_ctr(rd_ctr),
    .hit(pred_hit), .taken(pred_taken), .next_pc(next_pc)
  );

  assign pred_target = rd_target;
  assign pred_ctr    = rd_ctr;

  // R5: an allocation is read back next cycle as weakly taken at that address
  a_r5_alloc_weak: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && upd_alloc) |=> (fetch_pc != $past(upd_pc)) || (pred_hit && pred_ctr == CTR_WT));
  // R6: taken training at the top of the counter stays saturated
  a_r6_sat_top: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !upd_alloc && upd_taken && trn_hit && tr_ctr == CTR_ST)
      |=> (fetch_pc != $past(upd_pc)) || (pred_hit && pred_ctr == CTR_ST));
  // R7: an unmatched training update does not create a hit
  a_r7_no_create: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !upd_alloc && !trn_hit) |=> (fetch_pc != $past(upd_pc)) || !pred_hit);
  // R8: nothing hits on the cycle after a flush
  a_r8_flush_miss: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pred_hit);
endmodule

// File: tb/test_btb_core.sv
`timescale 1ns/1ps
module test_btb_core;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          pred_hit, pred_taken, upd_ready;
  logic [AW-1:0] pred_target, next_pc;
  logic [1:0]    pred_ctr;
  logic          upd_valid = 1'b0, upd_alloc = 1'b0, upd_taken = 1'b0;
  logic [AW-1:0] upd_pc = '0, upd_target = '0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [AW-1:0] pc;
    logic          hit;
    logic          tk;
    logic [AW-1:0] nxt;
    logic [1:0]    ctr;
    string         req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  btb_core i_btb_core (
    .clk(clk), .rst(rst), .flush(flush), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .pred_ctr(pred_ctr), .next_pc(next_pc),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_alloc(upd_alloc),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  // monitor: compares the combinational lookup mid-cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pred_hit !== e.hit || pred_taken !== e.tk || next_pc !== e.nxt ||
          (e.hit && pred_ctr !== e.ctr)) begin
        errors++;
        $display("FAIL %s pc=%h: hit=%b tk=%b next=%h ctr=%0d expected hit=%b tk=%b next=%h ctr=%0d",
                 e.req, e.pc, pred_hit, pred_taken, next_pc, pred_ctr, e.hit, e.tk, e.nxt, e.ctr);
      end
    end
  end

  task automatic lookup(input logic [AW-1:0] pc, input logic hit, input logic [1:0] ctr,
                        input logic [AW-1:0] tgt, input string req);
    exp_t e;
    @(posedge clk); #1;
    fetch_pc = pc;
    e.pc = pc; e.hit = hit; e.ctr = ctr;
    e.tk = hit && ctr[1];
    e.nxt = e.tk ? tgt : pc + 32'd4;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic update(input logic alloc, input logic [AW-1:0] pc, input logic tk,
                        input logic [AW-1:0] tgt);
    @(posedge clk); #1;
    upd_valid = 1'b1; upd_alloc = alloc; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    @(posedge clk); #1;
    upd_valid = 1'b0;
  endtask

  task automatic chk_ready(input logic exp, input string req);
    checks++;
    if (upd_ready !== exp) begin
      errors++;
      $display("FAIL %s upd_ready=%b expected %b", req, upd_ready, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: empty after reset
    lookup(32'h1000, 0, 0, 0, "R1");
    lookup(32'h0000_03FC, 0, 0, 0, "R1");
    chk_ready(1'b1, "R8");
    // R7: training a missing branch is ignored
    update(0, 32'h1000, 1, 32'h2000);
    lookup(32'h1000, 0, 0, 0, "R7");
    // R5: allocate, weakly taken; R3: same-cycle redirect
    update(1, 32'h1000, 1, 32'h2000);
    lookup(32'h1000, 1, 2, 32'h2000, "R5");
    lookup(32'h1004, 0, 0, 0, "R2");
    lookup(32'h1400, 0, 0, 0, "R2");
    // R6: train up with saturation
    update(0, 32'h1000, 1, 32'h2000);
    lookup(32'h1000, 1, 3, 32'h2000, "R6");
    update(0, 32'h1000, 1, 32'h2000);
    lookup(32'h1000, 1, 3, 32'h2000, "R6");
    // train down: 2 still taken, 1 sequential
    update(0, 32'h1000, 0, 32'h0);
    lookup(32'h1000, 1, 2, 32'h2000, "R3");
    update(0, 32'h1000, 0, 32'h0);
    lookup(32'h1000, 1, 1, 32'h2000, "R4");
    update(0, 32'h1000, 0, 32'h0);
    update(0, 32'h1000, 0, 32'h0);
    lookup(32'h1000, 1, 0, 32'h2000, "R6");
    // R6: taken training refreshes the target
    update(0, 32'h1000, 1, 32'h3000);
    lookup(32'h1000, 1, 1, 32'h3000, "R6");
    update(0, 32'h1000, 1, 32'h3000);
    lookup(32'h1000, 1, 2, 32'h3000, "R6");
    // R7: training with an aliasing tag leaves the entry alone
    update(0, 32'h1400, 0, 32'h0);
    lookup(32'h1000, 1, 2, 32'h3000, "R7");
    lookup(32'h1400, 0, 0, 0, "R7");
    // R9: aliasing allocation evicts
    update(1, 32'h1400, 1, 32'h5000);
    lookup(32'h1400, 1, 2, 32'h5000, "R9");
    lookup(32'h1000, 0, 0, 0, "R9");
    // R5: top index entry
    update(1, 32'h0000_03FC, 1, 32'h0100);
    lookup(32'h0000_03FC, 1, 2, 32'h0100, "R5");
    // R8: flush with a pending allocation
    @(posedge clk); #1;
    flush = 1'b1;
    upd_valid = 1'b1; upd_alloc = 1'b1; upd_pc = 32'h3000; upd_taken = 1'b1; upd_target = 32'h7000;
    #0.5 chk_ready(1'b0, "R8");
    @(posedge clk); #1;
    flush = 1'b0; upd_valid = 1'b0;
    lookup(32'h1400, 0, 0, 0, "R8");
    lookup(32'h0000_03FC, 0, 0, 0, "R8");
    lookup(32'h3000, 0, 0, 0, "R8");
    chk_ready(1'b1, "R8");
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule